// File: doc/BRIEF.md
# Fixed-Priority DMA Request Arbiter

This block sits between a set of DMA requesters and a system bus interface. Each channel raises a request line, and the block remembers it. When the arbiter is free, it picks the pending channel with the lowest index. In the next cycle it tells the bus interface that a DMA cycle follows, and it presents that channel's current address, its read/write setting and the sequential-access flag that was sampled with the request. The arbiter then waits for the bus interface to hand over the bus. On the first clock edge at which that bus-master acknowledge is seen, it pulses the chosen channel's peripheral acknowledge for one cycle and steps that channel's address counter.

Each channel owns an address counter. A load strobe presets the counter, and a per-channel direction input selects counting up or down. A power-down input stops all arbitration. A transfer already handed to the bus still runs to its acknowledge, but no later request is granted until reset.

Top module: `dma_prio_arbiter`

## Requirements
- R1: When several channels are pending, the grant goes to the lowest-numbered one (channel 0 has the highest priority).
- R2: Requests are sampled on the rising clock edge. The DMA-cycle indication comes one cycle after the sampling edge, so a peripheral acknowledge is never raised sooner than two clock edges after its request was sampled.
- R3: While the DMA-cycle indication is high and the bus-master acknowledge is low, the indication, address, read/write flag and sequential flag hold steady. The peripheral acknowledge rises on the first edge at which the bus-master acknowledge is high.
- R4: The peripheral acknowledge vector is one-hot or zero and lasts exactly one cycle. The DMA-cycle indication is low while it is high, and no new grant is made until it has dropped. After reset both are zero.
- R5: On each completed transfer, the served channel's counter steps by 1. It steps down when that channel's direction bit is 1 and up when it is 0, and it wraps modulo 2^16.
- R6: A load strobe writes the load value into that channel's counter. When a load and a completion hit the same channel on the same edge, the load value is kept.
- R7: Once power-down is seen, a transfer already indicated to the bus completes normally. No further DMA-cycle indication or acknowledge occurs until reset.
- R8: A request stays pending until it is acknowledged, so a request held for only one cycle is still served.
- R9: The sequential flag presented with a grant is the one sampled together with that channel's request. The read/write flag is the channel's read/write setting at grant time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Per-channel DMA request |
| seq_i | input | 4 | Per-channel sequential-access flag, sampled with the request |
| rw_i | input | 4 | Per-channel read/write setting |
| dir_dec_i | input | 4 | Per-channel count direction, 1 = decrement |
| load_i | input | 4 | Per-channel counter load strobe |
| load_val_i | input | 16 | Value written by a load strobe |
| pwr_down_i | input | 1 | Power-down interrupt, latched until reset |
| bus_ack_i | input | 1 | Bus-master acknowledge from the bus interface |
| dma_next_o | output | 1 | The next bus cycle is a DMA cycle |
| addr_o | output | 16 | Address of the granted channel |
| rw_o | output | 1 | Read/write flag of the granted channel |
| seq_o | output | 1 | Sequential flag of the granted channel |
| pack_o | output | 4 | Per-channel peripheral acknowledge |

## Verification
Two functions can meet in one cycle. The first is a counter load strobe arriving on the same edge that completes a transfer for that channel. The bench holds a grant with the bus-master acknowledge low, then raises the acknowledge and the load strobe together. It judges the result by the address shown at that channel's next grant, which must be the loaded value and not the stepped one. The second is power-down arriving while a grant is waiting for the bus. The bench checks that this transfer still completes and that the remaining pending channel is never indicated or acknowledged.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   typedef enum logic [1:0] {
      ARB_IDLE = 2'd0,
      ARB_WAIT = 2'd1,
      ARB_ACK  = 2'd2
   } arb_state_t;
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
   parameter int N              = 4,
   parameter bit HIGH_IDX_FIRST = 1'b0,
   localparam int IW            = $clog2(N)
) (
   input  logic [N-1:0]  pend_i,
   output logic [N-1:0]  oh_o,
   output logic [IW-1:0] idx_o,
   output logic          any_o
);
   generate
      if (N < 2) begin : g_bad_n
         $error("dma_arb_pick: N must be at least 2");
      end
      if (HIGH_IDX_FIRST) begin : g_high
         always_comb begin
            oh_o  = '0;
            idx_o = '0;
            for (int i = 0; i < N; i++) begin
               if (pend_i[i]) begin
                  oh_o  = '0;
                  oh_o[i] = 1'b1;
                  idx_o = IW'(i);
               end
            end
         end
      end else begin : g_low
         always_comb begin
            oh_o  = '0;
            idx_o = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (pend_i[i]) begin
                  oh_o  = '0;
                  oh_o[i] = 1'b1;
                  idx_o = IW'(i);
               end
            end
         end
      end
   endgenerate

   assign any_o = |pend_i;

   always_comb begin
      assert_pick_onehot_R1: assert ($onehot0(oh_o) && (any_o == (oh_o != '0)));
   end
endmodule

// File: rtl/dma_req_capture.sv
module dma_req_capture #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] seq_i,
   input  logic [N-1:0] mask_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o,
   output logic [N-1:0] seq_o
);
   logic [N-1:0] take;

   assign take = req_i & ~mask_i & ~clr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o <= '0;
      end else begin
         pend_o <= (pend_o | take) & ~clr_i;
      end
   end

   generate
      for (genvar g = 0; g < N; g++) begin : g_seq
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               seq_o[g] <= 1'b0;
            end else if (take[g] && !pend_o[g]) begin
               seq_o[g] <= seq_i[g];
            end
         end
      end
   endgenerate

   assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_o != '0) && (clr_i == '0) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: rtl/dma_addr_counter.sv
module dma_addr_counter #(
   parameter int W    = 16,
   parameter int STEP = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         done_i,
   input  logic         dec_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] STEP_V = W'(STEP);

   generate
      if (W < 2) begin : g_bad_w
         $error("dma_addr_counter: W must be at least 2");
      end
      if (STEP < 1) begin : g_bad_step
         $error("dma_addr_counter: STEP must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (load_i) begin
         cnt_o <= load_val_i;
      end else if (done_i) begin
         cnt_o <= dec_i ? cnt_o - STEP_V : cnt_o + STEP_V;
      end
   end

   assert_load_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> cnt_o == $past(load_val_i));
   assert_step_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !load_i) |=> cnt_o == ($past(dec_i) ? $past(cnt_o) - STEP_V
                                                     : $past(cnt_o) + STEP_V));
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 16,
   parameter int STEP   = 1,
   localparam int IW    = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req_i,
   input  logic [NUM_CH-1:0] seq_i,
   input  logic [NUM_CH-1:0] rw_i,
   input  logic [NUM_CH-1:0] dir_dec_i,
   input  logic [NUM_CH-1:0] load_i,
   input  logic [ADDR_W-1:0] load_val_i,
   input  logic              pwr_down_i,
   input  logic              bus_ack_i,
   output logic              dma_next_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              rw_o,
   output logic              seq_o,
   output logic [NUM_CH-1:0] pack_o
);
   arb_state_t        state_q;
   logic [NUM_CH-1:0] pend;
   logic [NUM_CH-1:0] seq_q;
   logic [NUM_CH-1:0] pick_oh;
   logic [IW-1:0]     pick_idx;
   logic              pick_any;
   logic [NUM_CH-1:0] gnt_oh_q;
   logic [NUM_CH-1:0] done;
   logic              lock_q;
   logic              locked;
   logic [ADDR_W-1:0] cnt [NUM_CH];

   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("dma_prio_arbiter: NUM_CH must be at least 2");
      end
      if (ADDR_W < 2) begin : g_bad_aw
         $error("dma_prio_arbiter: ADDR_W must be at least 2");
      end
   endgenerate

   assign done   = (state_q == ARB_WAIT && bus_ack_i) ? gnt_oh_q : '0;
   assign locked = lock_q | pwr_down_i;

   dma_req_capture #(.N(NUM_CH)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_i),
      .seq_i  (seq_i),
      .mask_i (pack_o),
      .clr_i  (done),
      .pend_o (pend),
      .seq_o  (seq_q)
   );

   dma_arb_pick #(.N(NUM_CH), .HIGH_IDX_FIRST(1'b0)) u_pick (
      .pend_i (pend),
      .oh_o   (pick_oh),
      .idx_o  (pick_idx),
      .any_o  (pick_any)
   );

   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_cnt
         dma_addr_counter #(.W(ADDR_W), .STEP(STEP)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (load_i[g]),
            .load_val_i (load_val_i),
            .done_i     (done[g]),
            .dec_i      (dir_dec_i[g]),
            .cnt_o      (cnt[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
      end else if (pwr_down_i) begin
         lock_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ARB_IDLE;
         gnt_oh_q <= '0;
         addr_o   <= '0;
         rw_o     <= 1'b0;
         seq_o    <= 1'b0;
         pack_o   <= '0;
      end else begin
         unique case (state_q)
            ARB_IDLE: begin
               if (pick_any && !locked) begin
                  state_q  <= ARB_WAIT;
                  gnt_oh_q <= pick_oh;
                  addr_o   <= cnt[pick_idx];
                  rw_o     <= rw_i[pick_idx];
                  seq_o    <= seq_q[pick_idx];
               end
            end
            ARB_WAIT: begin
               if (bus_ack_i) begin
                  state_q <= ARB_ACK;
                  pack_o  <= gnt_oh_q;
               end
            end
            ARB_ACK: begin
               state_q <= ARB_IDLE;
               pack_o  <= '0;
            end
            default: state_q <= ARB_IDLE;
         endcase
      end
   end

   assign dma_next_o = (state_q == ARB_WAIT);

   assert_pack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pack_o) && !(dma_next_o && (pack_o != '0)));
   assert_pack_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pack_o != '0) |=> (pack_o == '0) && !dma_next_o);
   assert_pack_after_bus_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_next_o && bus_ack_i) |=> (pack_o != '0) && !dma_next_o);
   assert_hold_while_waiting_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_next_o && !bus_ack_i) |=> dma_next_o && $stable(addr_o) && $stable(rw_o)
                                     && $stable(seq_o));
   assert_no_grant_when_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !dma_next_o) |=> !dma_next_o);
endmodule

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  req_i, seq_i, rw_i, dir_dec_i, load_i;
   logic [15:0] load_val_i;
   logic        pwr_down_i, bus_ack_i;
   logic        dma_next_o, rw_o, seq_o;
   logic [15:0] addr_o;
   logic [3:0]  pack_o;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   dma_prio_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .seq_i(seq_i), .rw_i(rw_i),
      .dir_dec_i(dir_dec_i), .load_i(load_i), .load_val_i(load_val_i),
      .pwr_down_i(pwr_down_i), .bus_ack_i(bus_ack_i), .dma_next_o(dma_next_o),
      .addr_o(addr_o), .rw_o(rw_o), .seq_o(seq_o), .pack_o(pack_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic load_ch(input int ch, input logic [15:0] v);
      @(negedge clk);
      load_i = 4'b0001 << ch;
      load_val_i = v;
      @(negedge clk);
      load_i = '0;
   endtask

   task automatic t_reset;
      check("R4 reset pack", {28'd0, pack_o}, 32'd0);
      check("R4 reset dma_next", {31'd0, dma_next_o}, 32'd0);
   endtask

   task automatic t_latency;
      @(negedge clk);
      bus_ack_i = 1'b0;
      req_i[2] = 1'b1;
      seq_i[2] = 1'b1;
      @(negedge clk);
      req_i[2] = 1'b0;
      seq_i[2] = 1'b0;
      check("R2 no indication one cycle after sampling", {31'd0, dma_next_o}, 32'd0);
      @(negedge clk);
      check("R2 indication", {31'd0, dma_next_o}, 32'd1);
      check("R5 ch2 address", {16'd0, addr_o}, 32'h3000);
      check("R9 rw flag ch2", {31'd0, rw_o}, 32'd0);
      check("R9 seq flag ch2", {31'd0, seq_o}, 32'd1);
      check("R2 no early ack", {28'd0, pack_o}, 32'd0);
      repeat (3) @(negedge clk);
      check("R3 waits for bus ack", {27'd0, dma_next_o, pack_o}, 32'h10);
      bus_ack_i = 1'b1;
      @(negedge clk);
      check("R3 ack on first edge", {28'd0, pack_o}, 32'b0100);
      check("R4 indication dropped", {31'd0, dma_next_o}, 32'd0);
      bus_ack_i = 1'b0;
      @(negedge clk);
      check("R4 ack one cycle", {28'd0, pack_o}, 32'd0);
   endtask

   task automatic t_serve(input logic [3:0] reqs, input int e0, input int e1, input int e2,
                          input logic [15:0] a0, input logic [15:0] a1, input logic [15:0] a2);
      int exp_ch [3];
      logic [15:0] exp_a [3];
      logic [15:0] last_a;
      int k;
      exp_ch = '{e0, e1, e2};
      exp_a  = '{a0, a1, a2};
      k = 0;
      last_a = '0;
      @(negedge clk);
      req_i = reqs;
      bus_ack_i = 1'b1;
      for (int cyc = 0; cyc < 40 && k < 3; cyc++) begin
         @(negedge clk);
         if (dma_next_o) last_a = addr_o;
         if (pack_o != '0) begin
            int got;
            got = -1;
            for (int i = 0; i < 4; i++) if (pack_o[i]) got = i;
            check("R1 grant order", got, exp_ch[k]);
            check("R5 address at grant", {16'd0, last_a}, {16'd0, exp_a[k]});
            if (got >= 0) req_i[got] = 1'b0;
            k++;
         end
      end
      check("R1 all channels served", k, 3);
      bus_ack_i = 1'b0;
      req_i = '0;
      @(negedge clk);
   endtask

   task automatic t_pulse;
      @(negedge clk);
      req_i[1] = 1'b1;
      @(negedge clk);
      req_i[1] = 1'b0;
      repeat (4) @(negedge clk);
      check("R8 pulse request granted", {31'd0, dma_next_o}, 32'd1);
      check("R8 pulse address", {16'd0, addr_o}, 32'h2001);
      check("R9 rw flag ch1", {31'd0, rw_o}, 32'd1);
      bus_ack_i = 1'b1;
      @(negedge clk);
      check("R8 pulse acknowledged", {28'd0, pack_o}, 32'b0010);
      bus_ack_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_collision;
      @(negedge clk);
      req_i[0] = 1'b1;
      repeat (2) @(negedge clk);
      check("R6 grant before collision", {15'd0, dma_next_o, addr_o}, 32'h1_1002);
      bus_ack_i = 1'b1;
      load_i = 4'b0001;
      load_val_i = 16'h5555;
      @(negedge clk);
      check("R6 transfer completes", {28'd0, pack_o}, 32'b0001);
      load_i = '0;
      req_i[0] = 1'b0;
      bus_ack_i = 1'b0;
      @(negedge clk);
      req_i[0] = 1'b1;
      repeat (2) @(negedge clk);
      check("R6 load value kept", {15'd0, dma_next_o, addr_o}, 32'h1_5555);
      bus_ack_i = 1'b1;
      @(negedge clk);
      req_i[0] = 1'b0;
      bus_ack_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_powerdown;
      int seen;
      @(negedge clk);
      req_i = 4'b0011;
      repeat (2) @(negedge clk);
      check("R7 grant before power-down", {31'd0, dma_next_o}, 32'd1);
      pwr_down_i = 1'b1;
      repeat (2) @(negedge clk);
      check("R7 in-flight grant held", {31'd0, dma_next_o}, 32'd1);
      bus_ack_i = 1'b1;
      @(negedge clk);
      check("R7 in-flight transfer completes", {28'd0, pack_o}, 32'b0001);
      req_i[0] = 1'b0;
      seen = 0;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         if (c == 3) pwr_down_i = 1'b0;
         if (dma_next_o || (c > 0 && pack_o != '0)) seen++;
      end
      check("R7 lockout after power-down", seen, 0);
      req_i = '0;
      bus_ack_i = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0;
      req_i = '0; seq_i = '0; load_i = '0; load_val_i = '0;
      rw_i = 4'b1010; dir_dec_i = 4'b0100;
      pwr_down_i = 1'b0; bus_ack_i = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      load_ch(0, 16'h1000);
      load_ch(1, 16'h2000);
      load_ch(2, 16'h3000);
      load_ch(3, 16'hFFFF);
      t_latency();
      t_serve(4'b1011, 0, 1, 3, 16'h1000, 16'h2000, 16'hFFFF);
      t_serve(4'b1101, 0, 2, 3, 16'h1001, 16'h2FFF, 16'h0000);
      t_pulse();
      t_collision();
      t_powerdown();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule